// File: doc/BRIEF.md
# PCI Interrupt Router

The router takes interrupt level-change events from PCI devices and turns them into a single interrupt line to the CPU. Each event carries the device's slot number and the interrupt pin it uses (0 to 3, meaning INTA to INTD). A board-specific swizzle maps that pair to an internal interrupt number starting at 32. The number minus 32 is a bit index into two 32-bit configuration words: an edge-select word and a polarity word.

When a source's edge-select bit is set, every event for it gives a one-cycle pulse on the CPU line. When the bit is clear, the line settles to the source's polarity bit and stays there until the next event. The level that comes with an event has no effect on the line. Slots outside the board map pass the pin number through untranslated. That number is below 32, so no configuration bit covers it, and the event drives the line low. The line is registered and comes out of reset low.

Top module: `pci_irq_router`

## Requirements
- R1: While reset is asserted, and after it is released with no event, `irq_o` is 0.
- R2: An event from slot 5 selects configuration bit index `pin` (internal number 32 + pin).
- R3: An event from slot 6 selects bit index 4 and an event from slot 7 selects bit index 5, whatever the pin.
- R4: An event from a slot s with 8 <= s <= 12 selects bit index (s - 8 + pin) + 6.
- R5: An event from any other slot is treated as level mode with polarity 0. `irq_o` is 0 in the cycle after the event, whatever the configuration words hold.
- R6: An event whose selected edge-select bit is 1 makes `irq_o` 1 in the cycle after the event. With no further event, `irq_o` returns to 0 one cycle later.
- R7: An event whose selected edge-select bit is 0 makes `irq_o` equal to the selected polarity bit in the cycle after the event.
- R8: `level_i` has no effect on `irq_o`.
- R9: With no event and no pulse in progress, `irq_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 1 | Level-change event strobe, one per cycle |
| slot_i | input | SLOT_W (5) | Slot number of the requesting device |
| pin_i | input | 2 | Interrupt pin index, 0 to 3 |
| level_i | input | 1 | Level reported with the event (has no effect) |
| edge_cfg_i | input | NUM_SRC (32) | Edge-select bit per source index |
| pol_cfg_i | input | NUM_SRC (32) | Polarity bit per source index, used in level mode |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
A wrong swizzle entry shows up in the cycle after an event from the affected slot and pin. The bench makes the edge and polarity bits of neighbouring indices differ, so a wrong index shows as a wrong level or as a missing or stray pulse. A pulse flag that fails to clear shows one cycle later, as a line that stays high or gets stuck. A flag that sets when it should not clears a level-mode line after one cycle. Random events across all slots, pins and configuration words, checked every cycle, expose such faults within a few cycles of the first event that reaches them.

// File: rtl/pci_irq_router_pkg.sv
package pci_irq_router_pkg;
  localparam int IRQ_BASE   = 32;
  localparam int NUM_W      = 7;
  localparam int PIN_W      = 2;
  localparam int SLOT_SB    = 5;   // south-bridge slot: four pins kept apart
  localparam int SLOT_VGA   = 6;
  localparam int SLOT_NIC   = 7;
  localparam int SLOT_X_LO  = 8;   // expansion slots, rotated by pin
  localparam int SLOT_X_HI  = 12;
  localparam int IDX_VGA    = 4;
  localparam int IDX_NIC    = 5;
  localparam int IDX_X_OFS  = 6;

  typedef struct packed {
    logic [NUM_W-1:0] num;
  } irq_num_t;

  typedef struct packed {
    logic valid;
    logic edge_mode;
    logic pol;
  } irq_sel_t;
endpackage

// File: rtl/pci_irq_swizzle.sv
module pci_irq_swizzle
  import pci_irq_router_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PIN_W-1:0]  pin_i,
  output irq_num_t          num_o
);
  int s, p;

  always_comb begin
    s = int'(slot_i);
    p = int'(pin_i);
    if (s == SLOT_SB)
      num_o.num = NUM_W'(IRQ_BASE + p);
    else if (s == SLOT_VGA)
      num_o.num = NUM_W'(IRQ_BASE + IDX_VGA);
    else if (s == SLOT_NIC)
      num_o.num = NUM_W'(IRQ_BASE + IDX_NIC);
    else if (s >= SLOT_X_LO && s <= SLOT_X_HI)
      num_o.num = NUM_W'(IRQ_BASE + IDX_X_OFS + (s - SLOT_X_LO) + p);
    else
      num_o.num = NUM_W'(p);  // untranslated
  end
endmodule

// File: rtl/pci_irq_cfg_sel.sv
module pci_irq_cfg_sel
  import pci_irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  irq_num_t           num_i,
  input  logic [NUM_SRC-1:0] edge_cfg_i,
  input  logic [NUM_SRC-1:0] pol_cfg_i,
  output irq_sel_t           sel_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  int idx;
  logic in_rng;
  logic [IDX_W-1:0] bit_idx;

  always_comb begin
    idx     = int'(num_i.num) - IRQ_BASE;
    in_rng  = (idx >= 0) && (idx < NUM_SRC);
    bit_idx = in_rng ? IDX_W'(idx) : '0;
    sel_o.valid     = in_rng;
    sel_o.edge_mode = in_rng & edge_cfg_i[bit_idx];
    sel_o.pol       = in_rng & pol_cfg_i[bit_idx];
  end
endmodule

// File: rtl/pci_irq_line_drv.sv
module pci_irq_line_drv
  import pci_irq_router_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ev_i,
  input  logic     level_i,
  input  irq_sel_t sel_i,
  output logic     irq_o
);
  logic irq_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (ev_i) begin
      if (!sel_i.valid) begin
        irq_q   <= 1'b0;
        pulse_q <= 1'b0;
      end else if (sel_i.edge_mode) begin
        irq_q   <= 1'b1;
        pulse_q <= 1'b1;
      end else begin
        irq_q   <= sel_i.pol;
        pulse_q <= 1'b0;
      end
    end else if (pulse_q) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  a_r6_pulse_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && sel_i.valid && sel_i.edge_mode) |=> irq_o);
  a_r6_pulse_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q && !ev_i) |=> !irq_o);
  a_r7_level_follows_pol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && sel_i.valid && !sel_i.edge_mode) |=> (irq_o == $past(sel_i.pol)));
  a_r8_level_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && sel_i.valid && !sel_i.edge_mode && (level_i != sel_i.pol))
      |=> (irq_o != $past(level_i)));
  a_r5_invalid_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i && !sel_i.valid) |=> !irq_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_i && !pulse_q) |=> $stable(irq_o));
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_router_pkg::*;
#(
  parameter int SLOT_W  = 5,
  parameter int NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ev_i,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [PIN_W-1:0]   pin_i,
  input  logic               level_i,
  input  logic [NUM_SRC-1:0] edge_cfg_i,
  input  logic [NUM_SRC-1:0] pol_cfg_i,
  output logic               irq_o
);
  irq_num_t num;
  irq_sel_t sel;

  pci_irq_swizzle #(.SLOT_W(SLOT_W)) u_swizzle (
    .slot_i (slot_i),
    .pin_i  (pin_i),
    .num_o  (num)
  );

  pci_irq_cfg_sel #(.NUM_SRC(NUM_SRC)) u_cfg_sel (
    .num_i      (num),
    .edge_cfg_i (edge_cfg_i),
    .pol_cfg_i  (pol_cfg_i),
    .sel_o      (sel)
  );

  pci_irq_line_drv u_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev_i),
    .level_i (level_i),
    .sel_i   (sel),
    .irq_o   (irq_o)
  );

  a_r2_sb_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(slot_i) == SLOT_SB) |-> (int'(num.num) == IRQ_BASE + int'(pin_i)));
  a_r3_fixed_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(slot_i) == SLOT_VGA || int'(slot_i) == SLOT_NIC)
      |-> (int'(num.num) == IRQ_BASE + int'(slot_i) - 2));
  a_r4_exp_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(slot_i) >= SLOT_X_LO && int'(slot_i) <= SLOT_X_HI)
      |-> (int'(num.num) == IRQ_BASE + int'(slot_i) - 2 + int'(pin_i)));
  a_r5_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(slot_i) < SLOT_SB || int'(slot_i) > SLOT_X_HI) |-> !sel.valid);
endmodule

// File: tb/pci_irq_router_tb.sv
module pci_irq_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev = 1'b0;
  logic [4:0]  slot = '0;
  logic [1:0]  pin = '0;
  logic        level = 1'b0;
  logic [31:0] edge_cfg = '0;
  logic [31:0] pol_cfg = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_irq = 1'b0;
  logic exp_pulse = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_irq_router u_dut (
    .clk_i (clk), .rst_ni (rst_n), .ev_i (ev), .slot_i (slot), .pin_i (pin),
    .level_i (level), .edge_cfg_i (edge_cfg), .pol_cfg_i (pol_cfg), .irq_o (irq)
  );

  function automatic int map_idx(input int s, input int p);
    if (s == 5) return p;
    if (s == 6) return 4;
    if (s == 7) return 5;
    if (s >= 8 && s <= 12) return s - 8 + p + 6;
    return -1;
  endfunction

  function automatic string tag_of(input logic e, input int s, input int p, input logic pul);
    int i;
    if (!e) return pul ? "R6" : "R9";
    i = map_idx(s, p);
    if (i < 0) return "R5";
    if (edge_cfg[i]) return "R6";
    return "R7";
  endfunction

  task automatic compare(input string tag);
    n_chk++;
    if (irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s: irq_o=%0b expected %0b (slot %0d pin %0d)", tag, irq, exp_irq, slot, pin);
    end
  endtask

  // drive at negedge, clock once, check at next negedge
  task automatic step(input logic e, input int s, input int p, input logic lv, input string tag);
    string t;
    int i;
    ev = e; slot = 5'(s); pin = 2'(p); level = lv;
    t = (tag == "") ? tag_of(e, s, p, exp_pulse) : tag;
    if (e) begin
      i = map_idx(s, p);
      if (i < 0)               begin exp_irq = 1'b0; exp_pulse = 1'b0; end
      else if (edge_cfg[i])    begin exp_irq = 1'b1; exp_pulse = 1'b1; end
      else                     begin exp_irq = pol_cfg[i]; exp_pulse = 1'b0; end
    end else if (exp_pulse) begin
      exp_irq = 1'b0; exp_pulse = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    compare(t);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    step(1'b0, 0, 0, 1'b0, "R1");

    // R2: slot 5, each pin selects its own bit
    pol_cfg = 32'h0000_0005;
    for (int p = 0; p < 4; p++) step(1'b1, 5, p, 1'b0, "R2");
    // R3: slots 6 and 7 ignore pin
    pol_cfg = 32'h0000_0010;
    for (int p = 0; p < 4; p++) step(1'b1, 6, p, 1'b0, "R3");
    for (int p = 0; p < 4; p++) step(1'b1, 7, p, 1'b0, "R3");
    pol_cfg = 32'h0000_0020;
    step(1'b1, 7, 2, 1'b0, "R3");
    step(1'b1, 6, 1, 1'b0, "R3");
    // R4: expansion slots, highest corner index 13
    pol_cfg = 32'h0000_2000;
    step(1'b1, 12, 3, 1'b0, "R4");
    step(1'b1, 12, 2, 1'b0, "R4");
    pol_cfg = 32'h0000_0040;
    step(1'b1, 8, 0, 1'b0, "R4");
    step(1'b1, 9, 0, 1'b0, "R4");
    // R5: untranslated slots ignore all-ones config
    pol_cfg = '1; edge_cfg = '0;
    step(1'b1, 5, 0, 1'b0, "R5");
    step(1'b1, 4, 3, 1'b1, "R5");
    step(1'b1, 5, 0, 1'b0, "R5");
    edge_cfg = '1;
    step(1'b1, 13, 0, 1'b1, "R5");
    step(1'b1, 31, 3, 1'b1, "R5");
    // R6: pulse then drop; back-to-back pulses
    edge_cfg = 32'h0000_0100; pol_cfg = '0;
    step(1'b1, 10, 0, 1'b0, "R6");
    step(1'b0, 0, 0, 1'b0, "R6");
    step(1'b1, 10, 0, 1'b1, "R6");
    step(1'b1, 10, 0, 1'b0, "R6");
    step(1'b0, 0, 0, 1'b0, "R6");
    // R9: level held with idle cycles
    pol_cfg = 32'h0000_0001; edge_cfg = '0;
    step(1'b1, 5, 0, 1'b0, "R7");
    for (int k = 0; k < 4; k++) step(1'b0, 5, 1, 1'b1, "R9");
    // R8: level input does not matter
    step(1'b1, 5, 0, 1'b0, "R8");
    step(1'b1, 5, 0, 1'b1, "R8");
    pol_cfg = '0;
    step(1'b1, 5, 0, 1'b1, "R8");
    step(1'b1, 5, 0, 1'b0, "R8");

    for (int n = 0; n < N_RAND; n++) begin
      if (($urandom % 16) == 0) begin
        edge_cfg = $urandom;
        pol_cfg  = $urandom;
      end
      step(($urandom % 3) != 0, int'($urandom % 16), int'($urandom % 4),
           1'($urandom), "");
    end
    finish_run();
  end
endmodule